// File: doc/BRIEF.md
# Serial EEPROM Read Engine (I2C Target)

This block is an I2C target that answers read transfers for a 2048-byte serial EEPROM. It runs in the system clock domain. It oversamples the SCL and SDA lines, turns edges into bus events, and pulls SDA low through an open-drain enable. It answers three read forms: a random read, a current-address read and a sequential read.

All three forms share one 11-bit address counter. The counter keeps its value between transfers. A write transfer that stops after its address byte loads the counter. Each byte sent out advances the counter. Past the top address the counter wraps to 000h. The address is split in two parts: the upper three bits travel in the device select byte, next to the fixed type field 1010, and the lower eight bits follow as the address byte.

The byte array has no write path. A parameter picks its content. The default gives FFh in every location, which is the blank state. A test fill returns an address-derived value, so that the order of addresses is visible on the bus.

Top module: `eeprom_rd_i2c`

## Requirements
- R1: Out of reset, and after it, sda_oe is 0. With the default fill (FILL_MODE=0) every byte read out is FFh, so the target never pulls SDA low during data bits.
- R2: A select byte whose upper four bits are 1010 and whose bit 0 (the RW bit) is 0 is acknowledged. The next byte is the address byte and is also acknowledged. The counter then loads {select bits 3:1, address byte}.
- R3: A repeated Start after the address byte, then a select byte with RW=1, is acknowledged. The first data byte sent is the one at the loaded address (random read).
- R4: A Start followed by a matching select byte with RW=1 returns the byte at the current counter value. In a read, select bits 3:1 are ignored (current-address read).
- R5: The counter advances by one for every byte the target starts to send. Nothing else changes it, apart from the load in R2.
- R6: When the master drives ACK (SDA low) on the ninth clock of a data byte, the byte at the next address follows on the next eight clocks (sequential read).
- R7: After the master drives NACK on the ninth clock, the target releases SDA. It keeps SDA released through any further clocks until the next Start.
- R8: From address 7FFh the counter wraps to 000h, and a sequential read continues from 000h.
- R9: A select byte whose type field is not 1010 gets no acknowledge. SDA stays released until the next Start, and the counter keeps its value.
- R10: Data goes out MSB first. sda_oe changes only while SCL is low, and the master's ACK/NACK is sampled on the ninth rising edge of SCL.
- R11: With FILL_MODE=1, the byte at address a is a[7:0] XOR {a[10:8], 5'b10101}.
- R12: A Stop right after the acknowledged address byte still leaves the counter loaded as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level as seen on the wired bus, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |

## Verification
The hardest condition to reach is the counter wrapping in the middle of a sequential read. The random-read path sets it up. A dummy write to 7FEh loads the counter, a repeated Start follows, and acknowledged reads then cross 7FFh into 000h. The address-derived fill makes every step visible on SDA.

A second target with the blank fill shares the same bus. Its acknowledges must match the first target's, and it must never pull SDA low during data bits. Mismatched select codes and extra clocks after a NACK are driven between reads. The bench then confirms that the next current-address read starts where the counter was left.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    localparam int ADDR_W   = 11;
    localparam int BYTE_W   = 8;
    localparam int BLK_W    = ADDR_W - BYTE_W;
    localparam int TYPE_W   = 4;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int SALT_W   = BYTE_W - BLK_W;
    localparam logic [TYPE_W-1:0] DEV_TYPE  = 4'b1010;
    localparam logic [SALT_W-1:0] FILL_SALT = 5'b10101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_TX,
        ST_TX_ACK
    } st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] fill_byte(input logic [ADDR_W-1:0] a);
        return a[BYTE_W-1:0] ^ {a[ADDR_W-1:BYTE_W], FILL_SALT};
    endfunction

endpackage

// File: rtl/eeprom_rd_sync.sv
module eeprom_rd_sync
    import eeprom_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] last;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pipe   <= '1;
                last_q <= 1'b1;
            end else begin
                pipe   <= {pipe[STAGES-2:0], raw[g]};
                last_q <= pipe[STAGES-1];
            end
        end

        assign cur[g]  = pipe[STAGES-1];
        assign last[g] = last_q;
    end

    // index 0 is SCL, index 1 is SDA
    always_comb begin
        ev.scl      = cur[0];
        ev.sda      = cur[1];
        ev.scl_rise = cur[0] & ~last[0];
        ev.scl_fall = ~cur[0] & last[0];
        ev.start    = cur[0] & last[0] & last[1] & ~cur[1];
        ev.stop     = cur[0] & last[0] & ~last[1] & cur[1];
    end

endmodule

// File: rtl/eeprom_rd_array.sv
module eeprom_rd_array
    import eeprom_rd_pkg::*;
#(
    parameter int FILL_MODE = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data
);

    if (FILL_MODE == 0) begin : g_blank
        logic unused_addr;
        assign unused_addr = ^addr;
        assign data = '1;
    end else begin : g_pattern
        assign data = fill_byte(addr);
    end

endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
    import eeprom_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cnt_o,
    output logic              sda_oe,
    output st_e               st_o,
    output logic              adv_o,
    output logic              ld_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    st_e               st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rx_full;
    logic              ack_seen;
    logic              mst_ack;
    logic              rw;
    logic [BLK_W-1:0]  blk;
    logic [ADDR_W-1:0] cnt;
    logic              oe;
    logic              adv;
    logic              ld;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_full  <= 1'b0;
            ack_seen <= 1'b0;
            mst_ack  <= 1'b0;
            rw       <= 1'b0;
            blk      <= '0;
            cnt      <= '0;
            oe       <= 1'b0;
            adv      <= 1'b0;
            ld       <= 1'b0;
        end else begin
            adv <= 1'b0;
            ld  <= 1'b0;
            if (ev.start) begin
                st      <= ST_DEV;
                bitcnt  <= '0;
                rx_full <= 1'b0;
                oe      <= 1'b0;
            end else if (ev.stop) begin
                st <= ST_IDLE;
                oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        oe <= 1'b0;
                    end
                    ST_DEV, ST_ADDR: begin
                        if (ev.scl_rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) rx_full <= 1'b1;
                        end else if (ev.scl_fall && rx_full) begin
                            rx_full  <= 1'b0;
                            ack_seen <= 1'b0;
                            if (st == ST_DEV) begin
                                if (rx_sh[BYTE_W-1 -: TYPE_W] == DEV_TYPE) begin
                                    oe  <= 1'b1;
                                    st  <= ST_DEV_ACK;
                                    rw  <= rx_sh[0];
                                    blk <= rx_sh[BLK_W:1];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                oe  <= 1'b1;
                                st  <= ST_ADDR_ACK;
                                cnt <= {blk, rx_sh};
                                ld  <= 1'b1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.scl_rise) begin
                            ack_seen <= 1'b1;
                        end else if (ev.scl_fall && ack_seen) begin
                            bitcnt <= '0;
                            if (rw) begin
                                tx_sh <= rd_data;
                                oe    <= ~rd_data[BYTE_W-1];
                                cnt   <= cnt + 1'b1;
                                adv   <= 1'b1;
                                st    <= ST_TX;
                            end else begin
                                oe <= 1'b0;
                                st <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_rise) begin
                            ack_seen <= 1'b1;
                        end else if (ev.scl_fall && ack_seen) begin
                            oe <= 1'b0;
                            st <= ST_IDLE;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                oe       <= 1'b0;
                                ack_seen <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= tx_sh << 1;
                                oe     <= ~tx_sh[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            ack_seen <= 1'b1;
                            mst_ack  <= ~ev.sda;
                        end else if (ev.scl_fall && ack_seen) begin
                            if (mst_ack) begin
                                bitcnt <= '0;
                                tx_sh  <= rd_data;
                                oe     <= ~rd_data[BYTE_W-1];
                                cnt    <= cnt + 1'b1;
                                adv    <= 1'b1;
                                st     <= ST_TX;
                            end else begin
                                oe <= 1'b0;
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        oe <= 1'b0;
                        st <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign cnt_o  = cnt;
    assign sda_oe = oe;
    assign st_o   = st;
    assign adv_o  = adv;
    assign ld_o   = ld;

endmodule

// File: rtl/eeprom_rd_i2c.sv
module eeprom_rd_i2c
    import eeprom_rd_pkg::*;
#(
    parameter int FILL_MODE   = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    bus_ev_t           ev;
    logic [ADDR_W-1:0] cnt;
    logic [BYTE_W-1:0] rd_data;
    st_e               st;
    logic              adv;
    logic              ld;
    logic              scl_sync;

    eeprom_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eeprom_rd_array #(.FILL_MODE(FILL_MODE)) u_array (
        .addr (cnt),
        .data (rd_data)
    );

    eeprom_rd_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .cnt_o   (cnt),
        .sda_oe  (sda_oe),
        .st_o    (st),
        .adv_o   (adv),
        .ld_o    (ld)
    );

    assign scl_sync = ev.scl;

endmodule

// File: rtl/eeprom_rd_i2c_chk.sv
module eeprom_rd_i2c_chk
    import eeprom_rd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_sync,
    input logic              sda_oe,
    input st_e               st,
    input logic [ADDR_W-1:0] cnt,
    input logic              adv,
    input logic              ld
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0) begin
            reset_release_chk: assert (!sda_oe);
        end
    end

    // R10
    oe_steady_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_sync && $past(scl_sync)) |-> $stable(sda_oe));

    // R7
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R9
    drive_source_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (st == ST_DEV_ACK || st == ST_ADDR_ACK || st == ST_TX));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |-> (cnt == $past(cnt) + 1'b1));

    // R8
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && ($past(cnt) == '1)) |-> (cnt == '0));

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !ld) |-> $stable(cnt));

endmodule

bind eeprom_rd_i2c eeprom_rd_i2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_sync (scl_sync),
    .sda_oe   (sda_oe),
    .st       (st),
    .cnt      (cnt),
    .adv      (adv),
    .ld       (ld)
);

// File: tb/eeprom_rd_i2c_tb.sv
module eeprom_rd_i2c_tb;

    localparam int H     = 8;
    localparam int DEPTH = 2048;
    localparam int WDOG  = 150000;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  scl = 1'b1;
    logic  sda_m = 1'b1;
    logic  oe_a, oe_b;
    logic  sda_bus;
    logic  win = 1'b0;
    logic  exp_a = 1'b0, exp_b = 1'b0;
    string cur_req = "R1";
    int    checks = 0, fails = 0;
    int    mcnt = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~oe_a & ~oe_b;

    eeprom_rd_i2c #(.FILL_MODE(1)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(oe_a));

    eeprom_rd_i2c u_ff (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(oe_b));

    // R11: address-derived fill of the pattern target
    function automatic logic [7:0] pat(input int a);
        logic [10:0] v;
        v = a[10:0];
        return v[7:0] ^ {v[10:8], 5'b10101};
    endfunction

    // reference compare on every clock of the SCL high phase (R10)
    always @(negedge clk) begin
        if (win) begin
            checks++;
            if (oe_a !== exp_a || oe_b !== exp_b) begin
                fails++;
                $display("FAIL %s: sda_oe pattern=%b blank=%b expected %b/%b at %0t",
                         cur_req, oe_a, oe_b, exp_a, exp_b, $time);
            end
        end
    end

    task automatic wait_h();
        repeat (H) @(posedge clk);
    endtask

    task automatic do_bit(input logic tx, input logic ea, input logic eb);
        repeat (2) @(posedge clk);
        sda_m = tx;
        repeat (H - 2) @(posedge clk);
        exp_a = ea;
        exp_b = eb;
        scl = 1'b1;
        win = 1'b1;
        wait_h();
        win = 1'b0;
        scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_h();
        scl = 1'b1;
        wait_h();
        sda_m = 1'b0;
        wait_h();
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        repeat (2) @(posedge clk);
        sda_m = 1'b0;
        wait_h();
        scl = 1'b1;
        wait_h();
        sda_m = 1'b1;
        wait_h();
    endtask

    task automatic send(input logic [7:0] b, input logic acked);
        for (int i = 7; i >= 0; i--) do_bit(b[i], 1'b0, 1'b0);
        do_bit(1'b1, acked, acked);
    endtask

    task automatic recv(input logic master_ack);
        logic [7:0] e;
        e = pat(mcnt);
        for (int i = 7; i >= 0; i--) do_bit(1'b1, ~e[i], 1'b0);
        do_bit(~master_ack, 1'b0, 1'b0);
        mcnt = (mcnt + 1) % DEPTH;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        // R1: released out of reset
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            checks++;
            if (oe_a !== 1'b0 || oe_b !== 1'b0) begin
                fails++;
                $display("FAIL R1: sda_oe after reset %b/%b expected 0/0", oe_a, oe_b);
            end
        end

        // R4 R11: current read from reset counter 000h
        cur_req = "R4";
        bus_start();
        send(8'hA1, 1'b1);
        recv(1'b0);
        bus_stop();

        // R2 R3 R6: random read at 2A5h, sequential through 2A7h
        cur_req = "R2";
        bus_start();
        send(8'hA4, 1'b1);
        send(8'hA5, 1'b1);
        mcnt = 'h2A5;
        cur_req = "R3";
        bus_start();
        send(8'hA7, 1'b1);
        recv(1'b1);
        cur_req = "R6";
        recv(1'b1);
        recv(1'b0);
        bus_stop();

        // R5: counter continues at 2A8h
        cur_req = "R5";
        bus_start();
        send(8'hA1, 1'b1);
        recv(1'b0);
        bus_stop();

        // R8: wrap across 7FFh
        cur_req = "R8";
        bus_start();
        send(8'hAE, 1'b1);
        send(8'hFE, 1'b1);
        mcnt = 'h7FE;
        bus_start();
        send(8'hA1, 1'b1);
        recv(1'b1);
        recv(1'b1);
        recv(1'b1);
        recv(1'b0);
        // R7: extra clocks after NACK stay released
        cur_req = "R7";
        send(8'h00, 1'b0);
        bus_stop();

        // R9: wrong type field ignored, counter untouched
        cur_req = "R9";
        bus_start();
        send(8'hB1, 1'b0);
        send(8'h55, 1'b0);
        bus_stop();
        bus_start();
        send(8'hA1, 1'b1);
        recv(1'b0);
        bus_stop();

        // R12: stop after address byte keeps counter loaded at 100h
        cur_req = "R12";
        bus_start();
        send(8'hA2, 1'b1);
        send(8'h00, 1'b1);
        bus_stop();
        mcnt = 'h100;
        bus_start();
        send(8'hAD, 1'b1);
        recv(1'b1);
        recv(1'b0);
        bus_stop();

        // R10 R11: a different pattern, MSB first, block bits 5
        cur_req = "R10";
        bus_start();
        send(8'hAA, 1'b1);
        send(8'h3C, 1'b1);
        mcnt = 'h53C;
        bus_start();
        send(8'hA1, 1'b1);
        recv(1'b1);
        recv(1'b0);
        bus_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule